// File: doc/BRIEF.md
# Variable-Length Serial Register Port

This block is a serial slave that fronts twelve configuration registers of unequal width. A host lowers the chip select and clocks in an instruction byte, most significant bit first. That byte gives the direction and the register address. A data phase follows. Its length in bytes is fixed by the addressed register and is not carried on the wire. Once that many bytes have passed, the port treats the next eight rising serial clock edges as a fresh instruction, so several accesses can run inside one chip-select window.

Written bytes land in shadow storage and do not reach the parallel outputs until a rising edge on the update strobe. That edge copies every shadow register into the active set at once. Reads return the active contents. Read data leaves on the shared data pin in three-wire mode, or on a dedicated output pin in four-wire mode. An abort input drops whatever access is in progress. Serial clock, chip select, data, abort and update are brought into the system clock domain through synchronizers before any logic uses them.

The controller has five named states:
- ST_IDLE: chip select is high.
- ST_INSTR: an instruction byte is being shifted in.
- ST_WRITE: data is being shifted in.
- ST_READ: data is being shifted out.
- ST_HOLD: abort is asserted.

It moves between them as follows:
- Raising chip select moves any state to ST_IDLE.
- Abort with chip select low moves any state to ST_HOLD.
- With chip select low and abort low, ST_IDLE and ST_HOLD move to ST_INSTR.
- ST_INSTR moves to ST_READ or ST_WRITE on its eighth rising edge.
- ST_WRITE and ST_READ return to ST_INSTR on the rising edge that completes their last byte.

Top module: `serreg_port`

## Requirements
- R1: The first eight rising serial clock edges after chip select falls, after a completed access, or after abort returns low form the instruction byte, shifted MSB first. Bit 7 high means read and low means write. Bits 3:0 are the address. Bits 6:4 have no effect.
- R2: The number of data bytes per address (hex) is: 0, 1, 8, 9 and B take 2 bytes; 2, 3 and 4 take 6; 5 and 7 take 4; 6 takes 3; A takes 1. In reg_out, address 0 occupies the lowest bits, and each next address sits directly above the previous one. Each register's most significant byte is its highest byte.
- R3: Write data is sampled on rising serial clock edges, MSB first, most significant byte first, and goes only to shadow storage. reg_out does not change until an update edge.
- R4: A rising edge on update copies every shadow register into reg_out in one system clock.
- R5: A read returns the active (reg_out) contents of the register, MSB first, most significant byte first. Each bit is driven after a falling serial clock edge and is held for the following rising edge.
- R6: After the full byte count of an access, the next eight rising edges are decoded as a new instruction without chip select being raised.
- R7: While abort is high, the current access ends at once and a partial byte is not written. After abort falls, the next eight rising edges form a new instruction.
- R8: While chip select is high, sdio_oe and sdo_oe are low and any partial access is discarded. The next access starts with a fresh instruction.
- R9: With four_wire low, read data appears on sdio_out under sdio_oe, and sdo_oe stays low. With four_wire high, read data appears on sdo under sdo_oe, and sdio_oe stays low.
- R10: After reset, reg_out is all zero and both output enables are low.
- R11: Addresses C to F take one data byte. Writes to them change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every serial input |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data into the port (both modes) |
| sdio_out | output | 1 | Read data on the shared pin (three-wire mode) |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| sdo | output | 1 | Read data on the dedicated output pin (four-wire mode) |
| sdo_oe | output | 1 | Drive enable for the dedicated output pin |
| abort | input | 1 | Active-high abort of the current access |
| update | input | 1 | Rising edge copies shadow registers to reg_out |
| four_wire | input | 1 | Selects the dedicated output pin for read data |
| reg_out | output | 320 | Active contents of all twelve registers, packed |

## Verification
The main function is exercised with single accesses to registers of every length class (one, two, three, four and six bytes), writes followed by reads both before and after an update, and several accesses chained inside one chip-select window. A mismatch in byte count shows up as misaligned data in the following access, and reading before an update separates shadow from active storage. Abort mid-byte, chip select raised mid-write and mid-read, an instruction with its ignored bits set, and high addresses show whether the port resynchronizes and leaves reg_out untouched. A four-wire read against a three-wire read shows which pin carries data and which enable stays low.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int ADDR_W    = 4;
    localparam int IDX_W     = 3;
    localparam int NUM_REGS  = 12;
    localparam int RD_BIT    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WRITE,
        ST_READ,
        ST_HOLD
    } port_state_t;

    // Data-phase length per address; unmapped addresses take one byte.
    function automatic int reg_bytes(input int a);
        case (a)
            0, 1, 8, 9, 11: return 2;
            2, 3, 4:        return 6;
            5, 7:           return 4;
            6:              return 3;
            default:        return 1;
        endcase
    endfunction

    // First byte slot of a register in the packed output.
    function automatic int reg_base(input int a);
        int s;
        s = 0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i < a) s += reg_bytes(i);
        end
        return s;
    endfunction

    function automatic int total_bytes();
        return reg_base(NUM_REGS);
    endfunction

    // Slot of byte k (0 = most significant) of register a.
    function automatic int byte_slot(input int a, input int k);
        return reg_base(a) + reg_bytes(a) - 1 - k;
    endfunction

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              abort_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  logic [BYTE_W-1:0] rd_byte,
    output port_state_t       state,
    output logic              wr_en,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              dout,
    output logic              drive
);

    port_state_t          state_q, state_d;
    logic [BIT_CNT_W-1:0] bitcnt_q;
    logic [BYTE_W-1:0]    shift_q, rsh_q, rx_byte;
    logic [ADDR_W-1:0]    addr_q;
    logic [IDX_W-1:0]     idx_q, last_q;
    logic                 dout_q, drive_q;
    logic                 live, shifting, byte_done, last_byte;

    assign rx_byte   = {shift_q[BYTE_W-2:0], din};
    assign live      = !cs_n_s && !abort_s;
    assign shifting  = live && sclk_rise &&
                       (state_q == ST_INSTR || state_q == ST_WRITE || state_q == ST_READ);
    assign byte_done = shifting && (bitcnt_q == BIT_CNT_W'(BYTE_W - 1));
    assign last_byte = (idx_q == last_q);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else if (abort_s) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: state_d = ST_INSTR;
                ST_INSTR: begin
                    if (byte_done) state_d = rx_byte[RD_BIT] ? ST_READ : ST_WRITE;
                end
                ST_WRITE, ST_READ: begin
                    if (byte_done && last_byte) state_d = ST_INSTR;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counters, shifters and output bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shift_q  <= '0;
            rsh_q    <= '0;
            addr_q   <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            dout_q   <= 1'b0;
            drive_q  <= 1'b0;
        end else if (!live) begin
            bitcnt_q <= '0;
            drive_q  <= 1'b0;
        end else begin
            if (shifting) begin
                bitcnt_q <= bitcnt_q + BIT_CNT_W'(1);
                shift_q  <= rx_byte;
            end
            if (state_q == ST_INSTR && byte_done) begin
                addr_q <= rx_byte[ADDR_W-1:0];
                idx_q  <= '0;
                last_q <= IDX_W'(reg_bytes(int'(rx_byte[ADDR_W-1:0])) - 1);
            end else if (byte_done) begin
                idx_q <= idx_q + IDX_W'(1);
            end
            if (state_q == ST_READ && sclk_fall) begin
                drive_q <= 1'b1;
                if (bitcnt_q == '0) begin
                    dout_q <= rd_byte[BYTE_W-1];
                    rsh_q  <= {rd_byte[BYTE_W-2:0], 1'b0};
                end else begin
                    dout_q <= rsh_q[BYTE_W-1];
                    rsh_q  <= {rsh_q[BYTE_W-2:0], 1'b0};
                end
            end
            if (state_d != ST_READ) drive_q <= 1'b0;
        end
    end

    assign state    = state_q;
    assign wr_en    = byte_done && (state_q == ST_WRITE) && (int'(addr_q) < NUM_REGS);
    assign cur_addr = addr_q;
    assign cur_idx  = idx_q;
    assign wr_data  = rx_byte;
    assign dout     = dout_q;
    assign drive    = drive_q;

endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
    import serreg_pkg::*;
#(
    parameter  int NBYTES = total_bytes(),
    localparam int SLOT_W = $clog2(NBYTES + 1),
    localparam int FLAT_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              upd_rise,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [FLAT_W-1:0] shadow_q,
    output logic [FLAT_W-1:0] active_q
);

    logic [SLOT_W-1:0] slot;
    logic              mapped;

    assign slot   = SLOT_W'(byte_slot(int'(addr), int'(idx)));
    assign mapped = int'(addr) < NUM_REGS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en && mapped) begin
            for (int g = 0; g < NBYTES; g++) begin
                if (slot == SLOT_W'(g)) shadow_q[g*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        active_q <= '0;
        else if (upd_rise) active_q <= shadow_q;
    end

    always_comb begin
        rd_byte = '0;
        for (int g = 0; g < NBYTES; g++) begin
            if (mapped && slot == SLOT_W'(g)) rd_byte = active_q[g*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/serreg_port.sv
module serreg_port
    import serreg_pkg::*;
#(
    parameter  int SYNC_STAGES = 2,
    localparam int OUT_W       = BYTE_W * total_bytes()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdio_in,
    output logic             sdio_out,
    output logic             sdio_oe,
    output logic             sdo,
    output logic             sdo_oe,
    input  logic             abort,
    input  logic             update,
    input  logic             four_wire,
    output logic [OUT_W-1:0] reg_out
);

    logic [4:0]        raw_in, sync_out;
    logic              sclk_s, cs_n_s, abort_s, upd_s, din_s;
    logic              sclk_p, upd_p;
    logic              sclk_rise, sclk_fall, upd_rise;
    port_state_t       state;
    logic              wr_en, dout, drive;
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [BYTE_W-1:0] wr_data, rd_byte;
    logic [OUT_W-1:0]  shadow_q;

    assign raw_in = {update, abort, cs_n, sclk, sdio_in};

    serreg_sync #(
        .W       (5),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b00100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    assign {upd_s, abort_s, cs_n_s, sclk_s, din_s} = sync_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= 1'b0;
            upd_p  <= 1'b0;
        end else begin
            sclk_p <= sclk_s;
            upd_p  <= upd_s;
        end
    end

    assign sclk_rise = sclk_s && !sclk_p;
    assign sclk_fall = !sclk_s && sclk_p;
    assign upd_rise  = upd_s && !upd_p;

    serreg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .abort_s   (abort_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (din_s),
        .rd_byte   (rd_byte),
        .state     (state),
        .wr_en     (wr_en),
        .cur_addr  (cur_addr),
        .cur_idx   (cur_idx),
        .wr_data   (wr_data),
        .dout      (dout),
        .drive     (drive)
    );

    serreg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (cur_addr),
        .idx      (cur_idx),
        .wr_data  (wr_data),
        .upd_rise (upd_rise),
        .rd_byte  (rd_byte),
        .shadow_q (shadow_q),
        .active_q (reg_out)
    );

    assign sdio_out = dout;
    assign sdo      = dout;
    assign sdio_oe  = !cs_n_s && !four_wire && drive;
    assign sdo_oe   = !cs_n_s && four_wire && drive;

endmodule

// File: rtl/serreg_port_chk.sv
module serreg_port_chk
    import serreg_pkg::*;
#(
    parameter int OUT_W = BYTE_W * total_bytes()
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_s,
    input logic              abort_s,
    input logic              upd_rise,
    input logic              four_wire,
    input logic              sdio_oe,
    input logic              sdo_oe,
    input port_state_t       state,
    input logic              wr_en,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [OUT_W-1:0]  shadow_q,
    input logic [OUT_W-1:0]  reg_out
);

    AST_CS_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> (!sdio_oe && !sdo_oe)); // R8

    AST_FOUR_WIRE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        four_wire |-> !sdio_oe); // R9

    AST_THREE_WIRE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !four_wire |-> !sdo_oe); // R9

    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_s && !cs_n_s) |=> (state == ST_HOLD)); // R7

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_rise |=> $stable(reg_out)); // R3

    AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_rise |=> (reg_out == $past(shadow_q))); // R4

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(cur_addr) < NUM_REGS)); // R11

    AST_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe || sdo_oe) |-> (state == ST_READ)); // R5

endmodule

bind serreg_port serreg_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .abort_s   (abort_s),
    .upd_rise  (upd_rise),
    .four_wire (four_wire),
    .sdio_oe   (sdio_oe),
    .sdo_oe    (sdo_oe),
    .state     (state),
    .wr_en     (wr_en),
    .cur_addr  (cur_addr),
    .shadow_q  (shadow_q),
    .reg_out   (reg_out)
);

// File: tb/serreg_port_test.sv
module serreg_port_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         sdio_in = 1'b0;
    logic         abort = 1'b0;
    logic         update = 1'b0;
    logic         four_wire = 1'b0;
    logic         sdio_out, sdio_oe, sdo, sdo_oe;
    logic [319:0] reg_out;

    int checks = 0;
    int errors = 0;
    int bad_sdo = 0;
    int bad_sdio = 0;
    int saw_sdo = 0;

    always #5 clk = ~clk;

    serreg_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdio_in   (sdio_in),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .abort     (abort),
        .update    (update),
        .four_wire (four_wire),
        .reg_out   (reg_out)
    );

    // Pin-mode monitor (R9)
    always @(posedge clk) begin
        if (rst_n) begin
            if (!four_wire && sdo_oe) bad_sdo++;
            if (four_wire && sdio_oe) bad_sdio++;
            if (four_wire && sdo_oe) saw_sdo++;
        end
    end

    function automatic int nbytes(input int a);
        if (a == 2 || a == 3 || a == 4) return 6;
        if (a == 5 || a == 7) return 4;
        if (a == 6) return 3;
        if (a == 10 || a > 11) return 1;
        return 2;
    endfunction

    function automatic int base_of(input int a);
        int s = 0;
        for (int i = 0; i < a; i++) s += nbytes(i);
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic r);
        sdio_in = b;
        tick(8);
        if (four_wire) r = sdo_oe ? sdo : 1'b0;
        else           r = sdio_oe ? sdio_out : 1'b0;
        sclk = 1'b1;
        tick(8);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) bitx(b[i], r[i]);
    endtask

    task automatic frame(input logic [7:0] instr, input int n, input logic [47:0] wd, output logic [47:0] rd);
        logic [7:0] rb;
        send_byte(instr, rb);
        rd = '0;
        for (int k = 0; k < n; k++) begin
            send_byte(wd[(n-1-k)*8 +: 8], rb);
            rd = {rd[39:0], rb};
        end
    endtask

    task automatic xfer(input logic [7:0] instr, input logic [47:0] wd, output logic [47:0] rd);
        cs_n = 1'b0;
        tick(8);
        frame(instr, nbytes(int'(instr[3:0])), wd, rd);
        tick(4);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic pulse_update();
        update = 1'b1;
        tick(6);
        update = 1'b0;
        tick(6);
    endtask

    // {op[1:0], addr[3:0], data[47:0]}: op 0 write, 1 read (data = expected), 2 update
    localparam logic [53:0] VEC [14] = '{
        {2'd0, 4'h2, 48'h0123456789AB},
        {2'd0, 4'hA, 48'h00000000005A},
        {2'd0, 4'h6, 48'h000000C0FFEE},
        {2'd1, 4'h2, 48'h000000000000},
        {2'd2, 4'h0, 48'h000000000000},
        {2'd1, 4'h2, 48'h0123456789AB},
        {2'd1, 4'hA, 48'h00000000005A},
        {2'd1, 4'h6, 48'h000000C0FFEE},
        {2'd0, 4'h5, 48'h0000DEADBEEF},
        {2'd0, 4'h0, 48'h000000001234},
        {2'd2, 4'h0, 48'h000000000000},
        {2'd1, 4'h5, 48'h0000DEADBEEF},
        {2'd1, 4'h0, 48'h000000001234},
        {2'd1, 4'hE, 48'h000000000000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0]  rd;
        logic [319:0] snap;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R10: reset state
        check(reg_out == '0, "R10 reg_out", reg_out[47:0], 48'h0);
        check(!sdio_oe && !sdo_oe, "R10 enables", {46'h0, sdio_oe, sdo_oe}, 48'h0);

        // Vector walk: R2 R3 R4 R5
        for (int v = 0; v < 14; v++) begin
            logic [1:0]  op;
            logic [3:0]  a;
            logic [47:0] d;
            {op, a, d} = VEC[v];
            if (op == 2'd0) begin
                xfer({4'h0, a}, d, rd);
            end else if (op == 2'd1) begin
                xfer({4'h8, a}, 48'h0, rd);
                check(rd == d, "R3 R5 R2 vector read", rd, d);
            end else begin
                pulse_update();
            end
        end

        // R2 R4: packed layout of reg_out
        check(reg_out[base_of(2)*8 +: 48] == 48'h0123456789AB, "R2 R4 layout addr2",
              reg_out[base_of(2)*8 +: 48], 48'h0123456789AB);
        check(reg_out[base_of(5)*8 +: 32] == 32'hDEADBEEF, "R2 R4 layout addr5",
              {16'h0, reg_out[base_of(5)*8 +: 32]}, 48'hDEADBEEF);
        check(reg_out[base_of(10)*8 +: 8] == 8'h5A, "R2 layout addr10",
              {40'h0, reg_out[base_of(10)*8 +: 8]}, 48'h5A);

        // R1: ignored instruction bits 6:4
        xfer(8'hF5, 48'h0, rd);
        check(rd == 48'hDEADBEEF, "R1 read with bits6:4 set", rd, 48'hDEADBEEF);
        xfer(8'h70, 48'h4321, rd);
        pulse_update();
        xfer(8'h80, 48'h0, rd);
        check(rd == 48'h4321, "R1 write with bits6:4 set", rd, 48'h4321);

        // R6: chained accesses in one chip-select window
        cs_n = 1'b0;
        tick(8);
        frame(8'h08, 2, 48'hAAAA, rd);
        frame(8'h09, 2, 48'h5555, rd);
        frame(8'h85, 4, 48'h0, rd);
        check(rd == 48'hDEADBEEF, "R6 chained read", rd, 48'hDEADBEEF);
        tick(4);
        cs_n = 1'b1;
        tick(8);
        pulse_update();
        xfer(8'h88, 48'h0, rd);
        check(rd == 48'hAAAA, "R6 chained write addr8", rd, 48'hAAAA);
        xfer(8'h89, 48'h0, rd);
        check(rd == 48'h5555, "R6 chained write addr9", rd, 48'h5555);

        // R7: abort mid-byte, then resync in the same window
        cs_n = 1'b0;
        tick(8);
        begin
            logic [7:0] rb;
            logic       rbit;
            send_byte(8'h08, rb);
            for (int i = 0; i < 4; i++) bitx(1'b1, rbit);
        end
        abort = 1'b1;
        tick(6);
        abort = 1'b0;
        tick(8);
        frame(8'h0B, 2, 48'hBEEF, rd);
        tick(4);
        cs_n = 1'b1;
        tick(8);
        pulse_update();
        xfer(8'h88, 48'h0, rd);
        check(rd == 48'hAAAA, "R7 aborted write discarded", rd, 48'hAAAA);
        xfer(8'h8B, 48'h0, rd);
        check(rd == 48'hBEEF, "R7 instruction after abort", rd, 48'hBEEF);

        // R8: chip select raised mid-write and mid-read
        cs_n = 1'b0;
        tick(8);
        begin
            logic [7:0] rb;
            logic       rbit;
            send_byte(8'h09, rb);
            for (int i = 0; i < 6; i++) bitx(1'b0, rbit);
        end
        cs_n = 1'b1;
        tick(8);
        pulse_update();
        xfer(8'h89, 48'h0, rd);
        check(rd == 48'h5555, "R8 partial write discarded", rd, 48'h5555);
        cs_n = 1'b0;
        tick(8);
        begin
            logic [7:0] rb;
            logic       rbit;
            send_byte(8'h82, rb);
            for (int i = 0; i < 3; i++) bitx(1'b0, rbit);
        end
        cs_n = 1'b1;
        tick(5);
        check(!sdio_oe && !sdo_oe, "R8 tristate on deselect", {46'h0, sdio_oe, sdo_oe}, 48'h0);
        tick(4);
        xfer(8'h09, 48'h3C3C, rd);
        pulse_update();
        xfer(8'h89, 48'h0, rd);
        check(rd == 48'h3C3C, "R8 fresh access after deselect", rd, 48'h3C3C);

        // R9: four-wire read on the dedicated pin
        four_wire = 1'b1;
        tick(4);
        xfer(8'h82, 48'h0, rd);
        check(rd == 48'h0123456789AB, "R9 four-wire read", rd, 48'h0123456789AB);
        check(saw_sdo > 0, "R9 sdo_oe asserted", 48'(saw_sdo), 48'h1);
        four_wire = 1'b0;
        tick(4);
        check(bad_sdo == 0 && bad_sdio == 0, "R9 wrong pin enabled",
              48'(bad_sdo + bad_sdio), 48'h0);

        // R11: unmapped addresses
        snap = reg_out;
        xfer(8'h0D, 48'hFF, rd);
        pulse_update();
        check(reg_out == snap, "R11 unmapped write", reg_out[47:0], snap[47:0]);
        cs_n = 1'b0;
        tick(8);
        frame(8'h8F, 1, 48'h0, rd);
        check(rd == 48'h0, "R11 unmapped read", rd, 48'h0);
        frame(8'h8A, 1, 48'h0, rd);
        check(rd == 48'h5A, "R11 one-byte length", rd, 48'h5A);
        tick(4);
        cs_n = 1'b1;
        tick(8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule